// File: doc/BRIEF.md
# Serial Port Hold-Pause Gate

This block sits between the raw pins of a serial peripheral slave port and the command interpreter behind it. It oversamples the select, serial clock, pause and data-in pins with a fast system clock, and turns them into qualified serial-clock edge pulses, a captured input bit and a drive-enable for the data-out pin. A host can pause a transaction by pulling the active-low pause pin, without deselecting the slave. While paused, no serial-clock edge reaches the interpreter, the data-out enable is forced off, and the shift and byte counters downstream keep their values, so the transfer resumes exactly where it stopped.

Entry to and exit from the paused state happen only during the low phase of the serial clock. A pause request or release seen while the serial clock is high waits until the clock next goes low. If the host deselects the slave while paused, the block issues a one-cycle reset pulse to the protocol logic and leaves the paused state.

Top module: `spi_hold_gate`

## Requirements
- R1: While reset is high and on the first cycles after it, sck_rise, sck_fall, proto_rst, so_oe and hold_active are all 0.
- R2: With select low (cs_n_pin = 0) and not paused, each rising serial-clock edge yields exactly one sck_rise pulse and each falling edge exactly one sck_fall pulse; the two never pulse in the same cycle.
- R3: With select low, the pause pin low (hold_n_pin = 0) and the serial clock low, hold_active becomes 1.
- R4: If the pause pin falls while the serial clock is high, hold_active stays 0 until the serial clock goes low; the falling serial-clock edge that ends that high phase is still passed as an sck_fall pulse.
- R5: hold_active returns to 0 only when the pause pin is high and the serial clock is low; a release while the serial clock is high waits for the next low phase.
- R6: While hold_active is 1, no sck_rise or sck_fall pulse is produced and so_oe is 0, whatever the serial clock and data-in do.
- R7: Deselecting (cs_n_pin = 1) while paused clears hold_active and produces exactly one proto_rst pulse; deselecting outside a pause produces none.
- R8: While deselected, the pause pin and the serial clock have no effect: hold_active stays 0 and no edge pulses appear.
- R9: A byte shifted in with a pause in its middle is received whole: si_bit captured at each sck_rise, MSB first, reassembles the byte sent, with no lost or extra edge.
- R10: so_oe equals so_oe_req while selected and not paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n_pin | input | 1 | Raw active-low slave select |
| sck_pin | input | 1 | Raw serial clock |
| hold_n_pin | input | 1 | Raw active-low pause request |
| si_pin | input | 1 | Raw serial data in |
| so_oe_req | input | 1 | Data-out drive request from the interpreter |
| sck_rise | output | 1 | One-cycle pulse per qualified rising serial-clock edge |
| sck_fall | output | 1 | One-cycle pulse per qualified falling serial-clock edge |
| si_bit | output | 1 | Data-in value captured with the last sck_rise |
| so_oe | output | 1 | Data-out drive enable after the pause override |
| proto_rst | output | 1 | One-cycle reset pulse to the protocol logic |
| hold_active | output | 1 | High while the port is paused |

## Verification
The assertions take for granted that the pins stay stable for several system-clock cycles between changes, so every serial-clock phase is seen by the synchroniser and no pin toggles twice inside its latency. They also assume the pause is only entered with select low, which the state machine itself enforces. The stimulus keeps each serial-clock half period at four system-clock cycles, changes data-in one cycle before a rising edge, and waits eight or more cycles after each pin change before reading the outputs.

// File: rtl/spihg_pkg.sv
package spihg_pkg;
  // Pin bundle positions inside the synchroniser vector
  localparam int PIN_SCK   = 0;
  localparam int PIN_CSN   = 1;
  localparam int PIN_HOLDN = 2;
  localparam int PIN_SI    = 3;
  localparam int PIN_W     = 4;
  // Idle levels loaded at reset: select and pause deasserted, clock and data low
  localparam logic [PIN_W-1:0] PIN_IDLE = 4'b0110;

  typedef enum logic {LINK_RUN = 1'b0, LINK_PAUSE = 1'b1} link_st_e;
endpackage

// File: rtl/spihg_sync.sv
module spihg_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{RST_VAL}};
    end else begin
      chain <= {chain[CHAIN_W-W-1:0], d};
    end
  end

  assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/spihg_hold_ctl.sv
module spihg_hold_ctl
  import spihg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic cs_n_s,
  input  logic sck_s,
  input  logic hold_n_s,
  output logic in_hold,
  output logic hold_nxt,
  output logic proto_rst
);
  link_st_e st_q, st_d;
  logic     cs_n_prev;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LINK_RUN: begin
        if (!cs_n_s && !hold_n_s && !sck_s) st_d = LINK_PAUSE;
      end
      LINK_PAUSE: begin
        if (cs_n_s)                    st_d = LINK_RUN;
        else if (hold_n_s && !sck_s)   st_d = LINK_RUN;
      end
      default: st_d = LINK_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= LINK_RUN;
      cs_n_prev <= 1'b1;
      proto_rst <= 1'b0;
    end else begin
      st_q      <= st_d;
      cs_n_prev <= cs_n_s;
      proto_rst <= (st_q == LINK_PAUSE) && cs_n_s && !cs_n_prev;
    end
  end

  assign in_hold  = (st_q == LINK_PAUSE);
  assign hold_nxt = (st_d == LINK_PAUSE);

  AST_ENTER_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    $rose(in_hold) |-> $past(!cs_n_s && !sck_s && !hold_n_s)); // R3
  AST_EXIT_QUALIFIED: assert property (@(posedge clk) disable iff (rst)
    $fell(in_hold) |-> $past(cs_n_s || (hold_n_s && !sck_s))); // R5
  AST_PAUSE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
    in_hold |-> $past(!cs_n_s)); // R8
  AST_RESET_SINGLE: assert property (@(posedge clk) disable iff (rst)
    proto_rst |=> !proto_rst); // R7
  AST_RESET_ENDS_PAUSE: assert property (@(posedge clk) disable iff (rst)
    proto_rst |-> !in_hold); // R7
endmodule

// File: rtl/spihg_edge_gate.sv
module spihg_edge_gate (
  input  logic clk,
  input  logic rst,
  input  logic sck_s,
  input  logic si_s,
  input  logic cs_n_s,
  input  logic hold_i,
  input  logic hold_nxt,
  input  logic so_oe_req,
  output logic rise_o,
  output logic fall_o,
  output logic bit_o,
  output logic so_oe_o
);
  logic sck_prev;
  logic pass;
  logic rise_raw;
  logic fall_raw;

  assign pass     = !cs_n_s && !hold_i;
  assign rise_raw = sck_s && !sck_prev;
  assign fall_raw = !sck_s && sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_prev <= 1'b0;
      rise_o   <= 1'b0;
      fall_o   <= 1'b0;
      bit_o    <= 1'b0;
      so_oe_o  <= 1'b0;
    end else begin
      sck_prev <= sck_s;
      rise_o   <= pass && rise_raw;
      fall_o   <= pass && fall_raw;
      if (pass && rise_raw) bit_o <= si_s;
      so_oe_o  <= so_oe_req && !cs_n_s && !hold_nxt;
    end
  end

  AST_RISE_OUTSIDE_PAUSE: assert property (@(posedge clk) disable iff (rst)
    rise_o |-> $past(!hold_i)); // R6
  AST_FALL_OUTSIDE_PAUSE: assert property (@(posedge clk) disable iff (rst)
    fall_o |-> $past(!hold_i)); // R6
  AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rise_o && fall_o)); // R2
  AST_OE_OFF_IN_PAUSE: assert property (@(posedge clk) disable iff (rst)
    hold_i |-> !so_oe_o); // R6
endmodule

// File: rtl/spi_hold_gate.sv
module spi_hold_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n_pin,
  input  logic sck_pin,
  input  logic hold_n_pin,
  input  logic si_pin,
  input  logic so_oe_req,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_bit,
  output logic so_oe,
  output logic proto_rst,
  output logic hold_active
);
  import spihg_pkg::*;

  logic [PIN_W-1:0] pins_raw;
  logic [PIN_W-1:0] pins_s;
  logic             in_hold;
  logic             hold_nxt;

  always_comb begin
    pins_raw            = '0;
    pins_raw[PIN_SCK]   = sck_pin;
    pins_raw[PIN_CSN]   = cs_n_pin;
    pins_raw[PIN_HOLDN] = hold_n_pin;
    pins_raw[PIN_SI]    = si_pin;
  end

  spihg_sync #(
    .W       (PIN_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (PIN_IDLE)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_s)
  );

  spihg_hold_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .cs_n_s    (pins_s[PIN_CSN]),
    .sck_s     (pins_s[PIN_SCK]),
    .hold_n_s  (pins_s[PIN_HOLDN]),
    .in_hold   (in_hold),
    .hold_nxt  (hold_nxt),
    .proto_rst (proto_rst)
  );

  spihg_edge_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .sck_s     (pins_s[PIN_SCK]),
    .si_s      (pins_s[PIN_SI]),
    .cs_n_s    (pins_s[PIN_CSN]),
    .hold_i    (in_hold),
    .hold_nxt  (hold_nxt),
    .so_oe_req (so_oe_req),
    .rise_o    (sck_rise),
    .fall_o    (sck_fall),
    .bit_o     (si_bit),
    .so_oe_o   (so_oe)
  );

  assign hold_active = in_hold;

  AST_NO_DRIVE_WHILE_PAUSED: assert property (@(posedge clk) disable iff (rst)
    !(so_oe && hold_active)); // R6
endmodule

// File: tb/spi_hold_gate_test.sv
module spi_hold_gate_test;
  localparam int CLK_PERIOD = 10;
  localparam int HP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, hold_n = 1'b1, si = 1'b0, oe_req = 1'b0;
  logic sck_rise, sck_fall, si_bit, so_oe, proto_rst, hold_active;

  int n_chk = 0;
  int n_bad = 0;
  int rise_n = 0, fall_n = 0, prst_n = 0;
  logic [7:0] shreg = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_hold_gate uut (
    .clk(clk), .rst(rst), .cs_n_pin(cs_n), .sck_pin(sck), .hold_n_pin(hold_n),
    .si_pin(si), .so_oe_req(oe_req), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .si_bit(si_bit), .so_oe(so_oe), .proto_rst(proto_rst), .hold_active(hold_active)
  );

  // Downstream model: counts pulses and shifts captured bits, sampled off-edge
  always @(negedge clk) begin
    if (!rst) begin
      if (sck_rise) begin
        rise_n++;
        shreg = {shreg[6:0], si_bit};
      end
      if (sck_fall) fall_n++;
      if (proto_rst) prst_n++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    si = b; idle(1);
    sck = 1'b1; idle(HP);
    sck = 1'b0; idle(HP);
  endtask

  task automatic t_reset();
    idle(3);
    chk("R1 rise in reset", sck_rise, 0);
    chk("R1 oe in reset", so_oe, 0);
    chk("R1 pause in reset", hold_active, 0);
    rst = 1'b0; idle(4);
    chk("R1 pause after reset", hold_active, 0);
    chk("R1 proto_rst after reset", proto_rst, 0);
    chk("R1 no edges after reset", rise_n + fall_n, 0);
  endtask

  task automatic t_plain_byte();
    int r0, f0, p0;
    r0 = rise_n; f0 = fall_n; p0 = prst_n;
    cs_n = 1'b0; idle(6);
    for (int i = 7; i >= 0; i--) send_bit(logic'((8'h3C >> i) & 1));
    idle(6);
    chk("R2 rise count", rise_n - r0, 8);
    chk("R2 fall count", fall_n - f0, 8);
    chk("R9 plain byte", int'(shreg), 8'h3C);
    cs_n = 1'b1; idle(8);
    chk("R7 no reset pulse outside pause", prst_n - p0, 0);
  endtask

  task automatic t_pause_low_phase();
    int r0, f0;
    cs_n = 1'b0; oe_req = 1'b1; idle(6);
    chk("R10 oe follows request", so_oe, 1);
    for (int i = 7; i >= 4; i--) send_bit(logic'((8'hA5 >> i) & 1));
    hold_n = 1'b0; idle(8);
    chk("R3 pause entered", hold_active, 1);
    chk("R6 oe off in pause", so_oe, 0);
    r0 = rise_n; f0 = fall_n;
    for (int k = 0; k < 3; k++) begin
      si = logic'(k & 1); sck = 1'b1; idle(HP); sck = 1'b0; idle(HP);
    end
    chk("R6 no rise in pause", rise_n - r0, 0);
    chk("R6 no fall in pause", fall_n - f0, 0);
    hold_n = 1'b1; idle(8);
    chk("R5 pause left", hold_active, 0);
    chk("R10 oe back", so_oe, 1);
    for (int i = 3; i >= 0; i--) send_bit(logic'((8'hA5 >> i) & 1));
    idle(6);
    chk("R9 byte across pause", int'(shreg), 8'hA5);
    oe_req = 1'b0; idle(4);
    chk("R10 oe drops with request", so_oe, 0);
    cs_n = 1'b1; idle(8);
  endtask

  task automatic t_deferred();
    int r0, f0, r_all;
    cs_n = 1'b0; idle(6);
    r_all = rise_n;
    send_bit(1'b1); send_bit(1'b0);
    si = 1'b1; idle(1); sck = 1'b1; idle(HP);
    hold_n = 1'b0; idle(10);
    chk("R4 no entry while clock high", hold_active, 0);
    f0 = fall_n;
    sck = 1'b0; idle(8);
    chk("R4 entry at clock low", hold_active, 1);
    chk("R4 closing fall passed", fall_n - f0, 1);
    r0 = rise_n;
    sck = 1'b1; idle(HP);
    hold_n = 1'b1; idle(10);
    chk("R5 exit waits for clock low", hold_active, 1);
    sck = 1'b0; idle(8);
    chk("R5 exit at clock low", hold_active, 0);
    chk("R6 suppressed rise", rise_n - r0, 0);
    for (int i = 4; i >= 0; i--) send_bit(logic'((8'hB3 >> i) & 1));
    idle(6);
    chk("R9 deferred byte", int'(shreg), 8'hB3);
    chk("R9 deferred rise total", rise_n - r_all, 8);
    cs_n = 1'b1; idle(8);
  endtask

  task automatic t_deselect_in_pause();
    int p0;
    cs_n = 1'b0; idle(6);
    for (int k = 0; k < 3; k++) send_bit(1'b1);
    hold_n = 1'b0; idle(8);
    chk("R3 pause before deselect", hold_active, 1);
    p0 = prst_n;
    cs_n = 1'b1; idle(8);
    chk("R7 single reset pulse", prst_n - p0, 1);
    chk("R7 pause cleared", hold_active, 0);
    hold_n = 1'b1; idle(6);
  endtask

  task automatic t_deselected_ignore();
    int r0, f0, p0;
    cs_n = 1'b1; idle(4);
    r0 = rise_n; f0 = fall_n; p0 = prst_n;
    hold_n = 1'b0; idle(8);
    for (int k = 0; k < 2; k++) send_bit(1'b1);
    idle(4);
    chk("R8 no pause when deselected", hold_active, 0);
    chk("R8 no edges when deselected", (rise_n - r0) + (fall_n - f0), 0);
    chk("R8 no reset pulse", prst_n - p0, 0);
    hold_n = 1'b1; idle(6);
  endtask

  initial begin
    t_reset();
    t_plain_byte();
    t_pause_low_phase();
    t_deferred();
    t_deselect_in_pause();
    t_deselected_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule